// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's complement operands of `OPW` bits (default 8) over several clock cycles and returns a signed product of `2*OPW` bits. A pulse on `start` while the block is idle captures both operands. The block then walks the multiplier one bit per cycle, starting at bit 0 and moving toward the top bit. It pairs each bit with the bit examined before it, and a zero is assumed below bit 0. That pair selects the work for the cycle. Where the pair shows the start of a run of ones, the aligned multiplicand is subtracted from the running partial product. Where it shows the end of a run of ones, the multiplicand is added. Inside a run of equal bits the partial product is only shifted.

Every cycle ends with an arithmetic right shift of the joined partial-product and multiplier register. After exactly `OPW` such cycles the block pulses `done` for one cycle. It then holds the product on its output until a later operation completes. The partial-product register is one bit wider than an operand, so the most negative multiplicand can be negated without corrupting the sign. A start request that arrives while the block is busy is ignored.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy`, `done` and `product` are all 0.
- R2: A `start` seen at a clock edge while `busy` is low raises `busy` from that edge on. `busy` stays high for exactly `OPW` cycles.
- R3: `done` is high for exactly one cycle, in the first cycle after `busy` falls. It is never high while `busy` is high.
- R4: When `done` is high, `product` equals the signed product of the `mcand` and `mplier` captured at the accepted start. It is written as a `2*OPW`-bit two's complement value.
- R5: Results are correct when either operand, or both, is the most negative value (for example -128 x -128 = 16384 at the default width).
- R6: A `start` seen while `busy` is high has no effect. Neither the timing nor the result of the running operation changes.
- R7: `product` changes only at the edge that raises `done`. It holds its value through the following operation until that operation completes.
- R8: A `start` in the cycle where `done` is high is accepted. `busy` rises at the next edge, and the new result follows `OPW` cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiplication; taken only while idle |
| mcand | input | OPW | Signed multiplicand, captured on an accepted start |
| mplier | input | OPW | Signed multiplier, captured on an accepted start |
| busy | output | 1 | High while the iterations run |
| done | output | 1 | One-cycle pulse when a new product is ready |
| product | output | 2*OPW | Signed product, held until the next completion |

## Verification
The completion pulse and the acceptance of a new request can land in the same cycle: `done` is high, `busy` is already low, and `start` is being sampled. The bench provokes this by raising `start` exactly in the `done` cycle, with operands that differ from the previous pair. A behavioural reference model runs alongside the design. It requires that the old product stays on the output for the whole new run, that `busy` rises at the next edge, and that the new product appears `OPW` cycles later with a fresh one-cycle `done`.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        OP_SHIFT = 2'd0,
        OP_ADD   = 2'd1,
        OP_SUB   = 2'd2
    } booth_op_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_t;

    // Pair (current bit, bit examined before it) selects the work for a step.
    function automatic booth_op_t booth_decode(input logic cur, input logic prev);
        booth_op_t op;
        case ({cur, prev})
            2'b10:   op = OP_SUB;   // entering a run of ones
            2'b01:   op = OP_ADD;   // leaving a run of ones
            default: op = OP_SHIFT; // inside a run
        endcase
        return op;
    endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic load,
    output logic step,
    output logic last
);
    localparam int CW = $clog2(OPW) + 1;

    ctl_state_t      state_q;
    logic [CW-1:0]   iter_q;

    assign busy = (state_q == ST_RUN);
    assign load = (state_q == ST_IDLE) && start;
    assign step = busy;
    assign last = busy && (iter_q == CW'(OPW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        iter_q  <= '0;
                    end
                end
                ST_RUN: begin
                    if (last) begin
                        state_q <= ST_IDLE;
                        iter_q  <= '0;
                    end else begin
                        iter_q <= iter_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/booth_alu.sv
module booth_alu
    import booth_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic [OPW:0]   acc,
    input  logic [OPW-1:0] mc,
    input  booth_op_t      op,
    output logic [OPW:0]   sum
);
    logic [OPW:0] mc_ext;

    assign mc_ext = {mc[OPW-1], mc};

    always_comb begin
        case (op)
            OP_ADD:  sum = acc + mc_ext;
            OP_SUB:  sum = acc - mc_ext;
            default: sum = acc;
        endcase
    end

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
    import booth_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 step,
    input  logic [OPW-1:0]       mcand_in,
    input  logic [OPW-1:0]       mplier_in,
    output logic [2*OPW-1:0]     result_next
);
    localparam int AW = OPW + 1;

    logic [AW-1:0]  acc_q,  acc_n;
    logic [OPW-1:0] mq_q,   mq_n;
    logic           tail_q, tail_n;
    logic [OPW-1:0] mc_q;
    logic [AW-1:0]  sum;
    booth_op_t      op;

    assign op = booth_decode(mq_q[0], tail_q);

    booth_alu #(.OPW(OPW)) u_alu (
        .acc (acc_q),
        .mc  (mc_q),
        .op  (op),
        .sum (sum)
    );

    // Arithmetic right shift of {acc, mq, tail} after the add/subtract.
    always_comb begin
        acc_n  = {sum[AW-1], sum[AW-1:1]};
        mq_n   = {sum[0], mq_q[OPW-1:1]};
        tail_n = mq_q[0];
    end

    assign result_next = {acc_n[OPW-1:0], mq_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            mq_q   <= '0;
            tail_q <= 1'b0;
            mc_q   <= '0;
        end else if (load) begin
            acc_q  <= '0;
            mq_q   <= mplier_in;
            tail_q <= 1'b0;
            mc_q   <= mcand_in;
        end else if (step) begin
            acc_q  <= acc_n;
            mq_q   <= mq_n;
            tail_q <= tail_n;
        end
    end

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult #(
    parameter int OPW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [OPW-1:0]       mcand,
    input  logic [OPW-1:0]       mplier,
    output logic                 busy,
    output logic                 done,
    output logic [2*OPW-1:0]     product
);
    localparam int PW = 2 * OPW;

    logic          load, step, last;
    logic [PW-1:0] result_next;
    logic [PW-1:0] prod_q;
    logic          done_q;

    booth_ctrl #(.OPW(OPW)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .load  (load),
        .step  (step),
        .last  (last)
    );

    booth_datapath #(.OPW(OPW)) u_dp (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .step        (step),
        .mcand_in    (mcand),
        .mplier_in   (mplier),
        .result_next (result_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (last) begin
                prod_q <= result_next;
            end
        end
    end

    assign product = prod_q;
    assign done    = done_q;

endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
    parameter int OPW = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic [OPW-1:0]       mcand,
    input logic [OPW-1:0]       mplier,
    input logic                 busy,
    input logic                 done,
    input logic [2*OPW-1:0]     product
);
    logic [31:0]               run_len;
    logic [OPW-1:0]            cap_a, cap_b;
    logic signed [2*OPW-1:0]   expect_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            cap_a   <= '0;
            cap_b   <= '0;
        end else begin
            run_len <= busy ? run_len + 1 : '0;
            if (start && !busy) begin
                cap_a <= mcand;
                cap_b <= mplier;
            end
        end
    end

    assign expect_p = $signed(cap_a) * $signed(cap_b);

    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r2_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < OPW));

    a_r2_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == OPW));

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r4_product_value: assert property (@(posedge clk) disable iff (rst)
        done |-> ($signed(product) == expect_p));

    a_r7_product_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(product));

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.OPW(OPW)) u_chk (.*);

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;
    localparam int OPW = 8;
    localparam int PW  = 2 * OPW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [OPW-1:0]  mcand = '0;
    logic [OPW-1:0]  mplier = '0;
    logic            busy, done;
    logic [PW-1:0]   product;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    booth_seq_mult #(.OPW(OPW)) uut (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .product(product)
    );

    always #5 clk = ~clk;

    // Behavioural reference model
    logic                  m_busy = 1'b0;
    logic                  m_done = 1'b0;
    logic signed [PW-1:0]  m_prod = '0;
    logic signed [PW-1:0]  m_pend = '0;
    int                    m_left = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0; m_done = 1'b0; m_prod = '0; m_left = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                    m_prod = m_pend;
                end
            end else if (start) begin
                m_busy = 1'b1;
                m_left = OPW;
                m_pend = $signed(mcand) * $signed(mplier);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(busy == m_busy, "R2 busy", busy, m_busy);
            check(done == m_done, "R3 done", done, m_done);
            check($signed(product) == m_prod, "R7 product", $signed(product), m_prod);
        end
    end

    task automatic issue(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
        @(negedge clk);
        while (busy) @(negedge clk);
        start = 1'b1; mcand = a; mplier = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic run_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b, input string tag);
        logic signed [PW-1:0] e;
        e = $signed(a) * $signed(b);
        issue(a, b);
        wait_done();
        check($signed(product) == e, tag, $signed(product), e);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic signed [PW-1:0] e1;
        logic signed [PW-1:0] e2;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(done == 1'b0, "R1 done in reset", done, 0);
        check(product == '0, "R1 product in reset", product, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 after reset", {busy, done}, 0);

        // R4: varied patterns
        run_op(8'd3, 8'd5, "R4 small positive");
        run_op(8'd0, 8'd77, "R4 zero multiplicand");
        run_op(8'd77, 8'd0, "R4 zero multiplier");
        run_op(8'hFF, 8'hFF, "R4 minus one squared");
        run_op(8'h55, 8'hAA, "R4 alternating bits");
        run_op(8'd127, 8'd127, "R4 max positive");
        run_op(8'h0F, 8'hF0, "R4 runs of ones");

        // R5: most negative operand
        run_op(8'h80, 8'h80, "R5 min times min");
        run_op(8'h80, 8'd127, "R5 min times max");
        run_op(8'h80, 8'd1, "R5 min times one");
        run_op(8'd1, 8'h80, "R5 one times min");
        run_op(8'h80, 8'hFF, "R5 min times minus one");

        // R6: start while busy ignored
        e1 = $signed(8'd9) * $signed(8'hF9);
        issue(8'd9, 8'hF9);
        start = 1'b1; mcand = 8'h80; mplier = 8'h80;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check($signed(product) == e1, "R6 ignored start result", $signed(product), e1);
        @(negedge clk);
        check(busy == 1'b0, "R6 no second run", busy, 0);

        // R8: start in the done cycle
        issue(8'd12, 8'd11);
        wait_done();
        e1 = $signed(8'd12) * $signed(8'd11);
        e2 = $signed(8'hE0) * $signed(8'd6);
        start = 1'b1; mcand = 8'hE0; mplier = 8'd6;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 accepted in done cycle", busy, 1);
        check($signed(product) == e1, "R8 old product held", $signed(product), e1);
        wait_done();
        check($signed(product) == e2, "R8 new product", $signed(product), e2);

        // Random sweep
        for (int i = 0; i < 300; i++) begin
            run_op(OPW'($urandom), OPW'($urandom), "R4 random");
        end

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule